// File: doc/BRIEF.md
# Token Transfer History Signature

This unit keeps a 64-bit running signature of every token transfer seen by one node of a translation-coherence checker. Each TLB has one instance and the memory node has one. Each transfer names three things: the physical address of the page-table entry whose token moved, the logical time of the move, and whether the node acquired the token or released it. The unit hashes the address and the time together. It adds that hash to the signature on a release and subtracts it on an acquire, with all arithmetic modulo 2^64. If every transfer in the system is matched, the signatures of all nodes added together come to zero. A transfer of the wrong entry, or a transfer stamped with the wrong time, leaves a non-zero residue that a central verifier can detect.

Two event ports, A and B, can each deliver one transfer per cycle. When both fire in the same cycle, their contributions are summed into a single update. The logical time arrives on each port as an input; the unit does not generate it.

A small two-state machine serves snapshot requests. Its states are SNAP_IDLE and SNAP_EMIT. A request moves it to SNAP_EMIT and captures the signature as it stands after that cycle's transfers. The transition back to SNAP_IDLE happens on the first cycle with no request, and the transition SNAP_EMIT→SNAP_EMIT happens on back-to-back requests. The signature itself keeps running without a break, so a snapshot never loses an update and never counts one twice.

Top module: `token_hist_sig`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, sig_o, snap_vld and snap_data are all zero.
- R2: A port with vld=1 and rel=1 (release) adds H(addr,time) to the signature, modulo 2^64. The new value appears on sig_o after the clock edge that samples the event.
- R3: A port with vld=1 and rel=0 (acquire) subtracts H(addr,time) from the signature, modulo 2^64.
- R4: H is computed from the key k = (addr << TIME_W) | time, zero-extended to 64 bits. The steps are: x = k ^ (k>>33); x = x*64'hFF51AFD7ED558CCD; x ^= x>>29; x = x*64'hC4CEB9FE1A85EC53; H = x ^ (x>>32). Every multiply keeps the low 64 bits.
- R5: Valid events on ports A and B in the same cycle are both applied in that cycle, as the sum of their two contributions.
- R6: A release followed by an acquire of the same address and time restores the signature exactly. This holds whether the two events fall in the same cycle on different ports or in different cycles.
- R7: In a cycle in which neither port is valid, the signature does not change.
- R8: If snap_req is high at a clock edge, snap_vld is high for the following cycle. snap_data then equals the signature including every event sampled at that same edge. If snap_req is low, snap_vld is low in the following cycle.
- R9: snap_data keeps its last captured value until the next request.
- R10: The same address with different times gives different contributions, so a release and an acquire whose times differ leave a non-zero residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Port A event valid |
| a_rel | input | 1 | Port A direction: 1 release, 0 acquire |
| a_addr | input | ADDR_W | Port A page-table-entry physical address |
| a_time | input | TIME_W | Port A logical time |
| b_vld | input | 1 | Port B event valid |
| b_rel | input | 1 | Port B direction: 1 release, 0 acquire |
| b_addr | input | ADDR_W | Port B page-table-entry physical address |
| b_time | input | TIME_W | Port B logical time |
| snap_req | input | 1 | Snapshot request |
| sig_o | output | 64 | Current running signature |
| snap_vld | output | 1 | Snapshot data valid (one cycle per request) |
| snap_data | output | 64 | Captured signature |

## Verification
The hardest case to reach is a snapshot that lands in the same cycle as two transfers. In that case the captured value must include both contributions, and it must not include anything from the next cycle. A second hard case is an exact same-cycle cancellation between a release and an acquire of the same entry, which random addresses almost never produce. The stimulus therefore draws addresses and times from small pools so that matches happen often. It also injects directed cycles that pair a request with dual-port traffic. A bench model recomputes the hash and the modular sum every cycle and compares all outputs.

// File: rtl/sig_pkg.sv
package sig_pkg;
    localparam int SIG_W = 64;
    typedef logic [SIG_W-1:0] sig_t;
    localparam sig_t MIX_C1 = 64'hFF51AFD7ED558CCD;
    localparam sig_t MIX_C2 = 64'hC4CEB9FE1A85EC53;
    typedef enum logic [0:0] {SNAP_IDLE = 1'b0, SNAP_EMIT = 1'b1} snap_state_t;
endpackage

// File: rtl/sig_hash_mix.sv
module sig_hash_mix
    import sig_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int TIME_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TIME_W-1:0] ltime,
    output sig_t              hash
);
    sig_t key, x0, x1, x2, x3;

    always_comb begin
        key  = sig_t'(ltime) | (sig_t'(addr) << TIME_W);
        x0   = key ^ (key >> 33);
        x1   = x0 * MIX_C1;
        x2   = x1 ^ (x1 >> 29);
        x3   = x2 * MIX_C2;
        hash = x3 ^ (x3 >> 32);
    end
endmodule

// File: rtl/sig_delta_merge.sv
module sig_delta_merge
    import sig_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic [NPORT-1:0] vld,
    input  logic [NPORT-1:0] rel,
    input  sig_t             hash [NPORT],
    output sig_t             delta
);
    sig_t term [NPORT];

    // Each valid port contributes +hash on a release and -hash on an acquire.
    for (genvar p = 0; p < NPORT; p++) begin : g_term
        always_comb begin
            if (!vld[p])     term[p] = '0;
            else if (rel[p]) term[p] = hash[p];
            else             term[p] = ~hash[p] + sig_t'(1);
        end
    end

    always_comb begin
        delta = '0;
        for (int p = 0; p < NPORT; p++) delta = delta + term[p];
    end
endmodule

// File: rtl/sig_snap_unit.sv
module sig_snap_unit
    import sig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  sig_t sig_next,
    output logic vld,
    output sig_t data
);
    snap_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            SNAP_IDLE: state_d = req ? SNAP_EMIT : SNAP_IDLE;
            SNAP_EMIT: state_d = req ? SNAP_EMIT : SNAP_IDLE;
            default:   state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   data <= '0;
        else if (req) data <= sig_next;
    end

    always_comb vld = (state_q == SNAP_EMIT);

    // R8
    snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> vld);
    // R8
    snap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !vld);
    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(data));
endmodule

// File: rtl/token_hist_sig.sv
module token_hist_sig
    import sig_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int TIME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic              a_rel,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [TIME_W-1:0] a_time,
    input  logic              b_vld,
    input  logic              b_rel,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [TIME_W-1:0] b_time,
    input  logic              snap_req,
    output logic [63:0]       sig_o,
    output logic              snap_vld,
    output logic [63:0]       snap_data
);
    localparam int NPORT = 2;
    localparam int KEY_W = ADDR_W + TIME_W;

    logic [ADDR_W-1:0] p_addr [NPORT];
    logic [TIME_W-1:0] p_time [NPORT];
    sig_t              p_hash [NPORT];
    sig_t              delta, sig_q, sig_d;

    always_comb begin
        p_addr[0] = a_addr; p_time[0] = a_time;
        p_addr[1] = b_addr; p_time[1] = b_time;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_hash
        sig_hash_mix #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_mix (
            .addr (p_addr[p]),
            .ltime(p_time[p]),
            .hash (p_hash[p])
        );
    end

    sig_delta_merge #(.NPORT(NPORT)) u_merge (
        .vld  ({b_vld, a_vld}),
        .rel  ({b_rel, a_rel}),
        .hash (p_hash),
        .delta(delta)
    );

    always_comb sig_d = sig_q + delta;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    sig_snap_unit u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (snap_req),
        .sig_next(sig_d),
        .vld     (snap_vld),
        .data    (snap_data)
    );

    always_comb sig_o = sig_q;

    initial begin
        key_width_chk: assert (KEY_W <= SIG_W);
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_vld && !b_vld) |=> $stable(sig_o));
    // R6
    match_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && b_vld && a_addr == b_addr && a_time == b_time && a_rel != b_rel)
        |=> $stable(sig_o));
    // R8
    snap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_vld |-> snap_data == sig_o);
endmodule

// File: tb/tb_token_hist_sig.sv
module tb_token_hist_sig;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_vld = 0, a_rel = 0, b_vld = 0, b_rel = 0, snap_req = 0;
    logic [39:0] a_addr = '0, b_addr = '0;
    logic [23:0] a_time = '0, b_time = '0;
    logic [63:0] sig_o, snap_data;
    logic        snap_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_sig = '0, m_snap = '0;
    bit          m_snapv = 0;

    always #(CLK_P/2) clk = ~clk;

    token_hist_sig dut (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_rel(a_rel), .a_addr(a_addr), .a_time(a_time),
        .b_vld(b_vld), .b_rel(b_rel), .b_addr(b_addr), .b_time(b_time),
        .snap_req(snap_req), .sig_o(sig_o), .snap_vld(snap_vld), .snap_data(snap_data)
    );

    function automatic logic [63:0] hmix(input logic [39:0] ad, input logic [23:0] tm);
        logic [63:0] x;
        x = {ad, tm};
        x = x ^ (x >> 33);
        x = x * 64'hFF51AFD7ED558CCD;
        x = x ^ (x >> 29);
        x = x * 64'hC4CEB9FE1A85EC53;
        return x ^ (x >> 32);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag,
                        input bit av, input bit ar, input logic [39:0] aa, input logic [23:0] at,
                        input bit bv, input bit br, input logic [39:0] ba, input logic [23:0] bt,
                        input bit sr);
        logic [63:0] ns;
        a_vld = av; a_rel = ar; a_addr = aa; a_time = at;
        b_vld = bv; b_rel = br; b_addr = ba; b_time = bt;
        snap_req = sr;
        ns = m_sig;
        if (av) ns = ar ? ns + hmix(aa, at) : ns - hmix(aa, at);
        if (bv) ns = br ? ns + hmix(ba, bt) : ns - hmix(ba, bt);
        m_sig = ns;
        m_snapv = sr;
        if (sr) m_snap = ns;
        @(posedge clk);
        @(negedge clk);
        chk(tag, sig_o, m_sig);
        chk("R8", {63'd0, snap_vld}, {63'd0, m_snapv});
        if (m_snapv) chk("R8", snap_data, m_snap);
        else         chk("R9", snap_data, m_snap);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] base;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", sig_o, 64'd0);
        chk("R1", {63'd0, snap_vld}, 64'd0);
        chk("R1", snap_data, 64'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", sig_o, 64'd0);

        // R2 single release, R4 hash form (model computes H independently)
        step("R2", 1, 1, 40'h12_3456_789A, 24'h000010, 0, 0, '0, '0, 0);
        chk("R4", sig_o, hmix(40'h12_3456_789A, 24'h000010));
        // R3 acquire on port B
        step("R3", 0, 0, '0, '0, 1, 0, 40'h00_0000_1000, 24'h000011, 0);
        // R7 idle cycles
        step("R7", 0, 0, '0, '0, 0, 0, '0, '0, 0);
        step("R7", 0, 1, 40'hFF, 24'h5, 0, 1, 40'hEE, 24'h6, 0);
        // R5 two releases in one cycle
        step("R5", 1, 1, 40'hA0, 24'h20, 1, 1, 40'hB0, 24'h21, 0);
        // R6 same-cycle cancellation
        base = m_sig;
        step("R6", 1, 1, 40'hC0FFEE, 24'h30, 1, 0, 40'hC0FFEE, 24'h30, 0);
        chk("R6", sig_o, base);
        // R6 across cycles
        step("R6", 1, 1, 40'h777, 24'h40, 0, 0, '0, '0, 0);
        step("R6", 0, 0, '0, '0, 1, 0, 40'h777, 24'h40, 0);
        chk("R6", sig_o, base);
        // R10 time mismatch leaves residue
        step("R10", 1, 1, 40'h888, 24'h50, 0, 0, '0, '0, 0);
        step("R10", 1, 0, 40'h888, 24'h51, 0, 0, '0, '0, 0);
        checks++;
        if (sig_o == base) begin
            errors++;
            $display("FAIL R10 actual=%h expected!=%h", sig_o, base);
        end
        // R8 snapshot with dual-port traffic in request cycle
        step("R8", 1, 1, 40'h9, 24'h60, 1, 0, 40'hA, 24'h61, 1);
        step("R9", 1, 1, 40'hB, 24'h62, 0, 0, '0, '0, 0);
        step("R8", 0, 0, '0, '0, 1, 1, 40'hC, 24'h63, 1);
        step("R8", 1, 0, 40'hD, 24'h64, 0, 0, '0, '0, 1);
        step("R9", 0, 0, '0, '0, 0, 0, '0, '0, 0);

        // Random traffic from small pools so matches recur
        for (int i = 0; i < 3000; i++) begin
            bit av, ar, bv, br, sr;
            logic [39:0] aa, ba;
            logic [23:0] at, bt;
            av = ($urandom % 3) != 0; ar = $urandom % 2;
            bv = ($urandom % 3) != 0; br = $urandom % 2;
            aa = 40'($urandom % 4) + 40'h1000; at = 24'($urandom % 3);
            ba = 40'($urandom % 4) + 40'h1000; bt = 24'($urandom % 3);
            sr = ($urandom % 5) == 0;
            if (($urandom % 8) == 0) begin ba = aa; bt = at; br = ~ar; av = 1; bv = 1; end
            step(av || bv ? "R5" : "R7", av, ar, aa, at, bv, br, ba, bt, sr);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule